// File: doc/BRIEF.md
# Transmit DMA Channel Control and Credit Checker

This block holds the control and status state for eight transmit DMA channels. Each channel has a configuration register, which sets its operating mode and whether it may raise internal requests that use credit, and a transfer credit counter. Software loads the counter, and each granted transfer lowers it by one. The block reports which channels have empty buffers and which have no pending request in a shared status word. It also watches for credit mismatches and for activation commands that arrive while a channel's request buffer is still full.

Each detected error sets its own sticky bit in an error register. Software clears a bit by writing a 1 to it. The error interrupt stays high while any error bit is set. The block has a simple register write port and a combinational read port, plus per-channel status inputs and one scheduler activation port. The frame data path and the transmit FIFOs are outside this block.

Top module: `tx_dma_credit_ctl`

## Requirements
- R1: After reset, all configuration, credit and error registers read 0, every request buffer is empty, and `err_irq` is low.
- R2: The configuration register of channel i is at byte address 0x20*i, and its credit register is at 0x20*i+0x4. Only configuration bits 31:30 (mode) and bit 3 (request/credit enable) are stored; all other bits read 0. The credit register stores the low CRED_W bits of the written data.
- R3: Mode 2'b10 drives `ch_run[i]` high. Mode 2'b01 drives `ch_stop_eof[i]` high. Modes 2'b00 and 2'b11 drive both low.
- R4: `ch_req_en[i]` equals configuration bit 3 of channel i.
- R5: While bit 3 is set, each cycle with `xfer_grant[i]` high lowers channel i's credit by one. The credit stays at 0 rather than wrapping. While bit 3 is clear, grants leave the credit unchanged.
- R6: A cycle with `fifo_full[i]` high, bit 3 set and a nonzero credit sets error bit i (bits 7:0). With a zero credit, or with bit 3 clear, no error is set.
- R7: `act_valid` with `act_chan`=i fills channel i's request buffer, and `cmd_done[i]` empties it. An activation aimed at a full buffer sets error bit 9+i (bits 16:9).
- R8: The status word at 0x100 carries `buf_empty` in bits 31:24 and, in bits 23:16, a 1 for each channel whose request buffer is empty. All other bits read 0.
- R9: `addr_err_evt` sets error bit 31 and `wc_err_evt` sets error bit 30.
- R10: Writing the error register at 0x108 clears each bit written as 1 and leaves bits written as 0 unchanged.
- R11: When an error event and a clearing write hit the same bit in one cycle, the bit ends up set.
- R12: `err_irq` is high exactly when at least one error bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Read data (combinational) |
| fifo_full | input | NCH | Per-channel transmit FIFO full indication |
| xfer_grant | input | NCH | Per-channel granted transfer, consumes one credit |
| buf_empty | input | NCH | Per-channel buffers-empty status from the data path |
| act_valid | input | 1 | Scheduler activation command strobe |
| act_chan | input | CH_W | Channel targeted by the activation |
| cmd_done | input | NCH | Per-channel request buffer release |
| addr_err_evt | input | 1 | Internal address error event |
| wc_err_evt | input | 1 | Data word count mismatch event |
| ch_run | output | NCH | Channel in normal mode |
| ch_stop_eof | output | NCH | Channel pausing at end of frame |
| ch_req_en | output | NCH | Internal request and credit use enabled |
| err_irq | output | 1 | Error interrupt |

## Verification
The bench targets the places where a credit counter or sticky error logic usually goes wrong. A grant at zero credit would wrap the counter to 0xFF if the floor were missing. A full indication with zero credit must set no error, so a checker that tested the wrong polarity would flag the healthy case. An activation into an empty buffer must not raise the overflow bit, while a second activation must. A clearing write in the same cycle as a new event must not drop that event, and a write-1-to-clear that also cleared bits written as 0 would wipe unrelated errors. Writes with reserved bits set, the reserved mode 2'b11, and grants while credit use is disabled cover the remaining decode corners.

// File: rtl/tx_dma_pkg.sv
// Package: shared types and fixed register layout for the transmit DMA
// channel control block. Assumes 32-bit registers and a byte-addressed map.
package tx_dma_pkg;

    typedef enum logic [1:0] {
        MODE_OFF       = 2'b00,
        MODE_STOP_EOF  = 2'b01,
        MODE_RUN       = 2'b10,
        MODE_RSVD      = 2'b11
    } tx_mode_e;

    localparam int REG_W        = 32;
    localparam int CH_STRIDE_SH = 5;      // 0x20 byte channel stride
    localparam int CH_FIELD_W   = 3;      // up to 8 channel slots
    localparam int CFG_OFS      = 0;      // word offset within slot
    localparam int CRED_OFS     = 1;
    localparam int STAT_ADDR    = 'h100;
    localparam int ERR_ADDR     = 'h108;
    localparam int MODE_MSB     = 31;
    localparam int MODE_LSB     = 30;
    localparam int CEN_BIT      = 3;
    localparam int EMPTY_LSB    = 24;
    localparam int IDLE_LSB     = 16;
    localparam int OVF_LSB      = 9;
    localparam int WC_ERR_BIT   = 30;
    localparam int ADR_ERR_BIT  = 31;

endpackage

// File: rtl/tx_chan_slice.sv
// Module: one transmit channel. Holds the mode and credit-enable bits, the
// credit counter and the request-buffer occupancy flag, and raises one-cycle
// error events. Assumes write strobes are already decoded for this channel.
module tx_chan_slice
    import tx_dma_pkg::*;
#(
    parameter int CRED_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  tx_mode_e          cfg_mode_in,
    input  logic              cfg_cen_in,
    input  logic              cred_we,
    input  logic [CRED_W-1:0] cred_in,
    input  logic              grant,
    input  logic              fifo_full,
    input  logic              act_hit,
    input  logic              cmd_done,
    output tx_mode_e          mode,
    output logic              cen,
    output logic [CRED_W-1:0] credit,
    output logic              occupied,
    output logic              cred_err_evt,
    output logic              act_ovf_evt
);

    localparam logic [CRED_W-1:0] CRED_ZERO = '0;
    localparam logic [CRED_W-1:0] CRED_ONE  = CRED_W'(1);

    logic cred_nonzero;
    assign cred_nonzero = (credit != CRED_ZERO);

    // Configuration register: mode and credit enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_OFF;
            cen  <= 1'b0;
        end else if (cfg_we) begin
            mode <= cfg_mode_in;
            cen  <= cfg_cen_in;
        end
    end

    // Credit counter: a software load wins, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            credit <= CRED_ZERO;
        end else if (cred_we) begin
            credit <= cred_in;
        end else if (grant && cen && cred_nonzero) begin
            credit <= credit - CRED_ONE;
        end
    end

    // Request buffer occupancy: an activation fills it, release empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occupied <= 1'b0;
        end else if (act_hit) begin
            occupied <= 1'b1;
        end else if (cmd_done) begin
            occupied <= 1'b0;
        end
    end

    // Error events for this channel, judged against the current state.
    always_comb begin
        cred_err_evt = fifo_full && cen && cred_nonzero;
        act_ovf_evt  = act_hit && occupied;
    end

endmodule

// File: rtl/tx_err_w1c.sv
// Module: sticky error register with write-1-to-clear. A set event in the
// same cycle as a clear of that bit leaves the bit set.
module tx_err_w1c #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr_we,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] err_q
);

    logic [W-1:0] clr_eff;
    assign clr_eff = clr_we ? clr_mask : '0;

    // Update: clear the requested bits first, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= (err_q & ~clr_eff) | set_vec;
        end
    end

endmodule

// File: rtl/tx_dma_credit_ctl.sv
// Module: top of the transmit DMA channel control block. Decodes register
// writes, instantiates one slice per channel, gathers error events into the
// sticky error register and muxes read data. Assumes NCH <= 8 and a
// combinational read port.
module tx_dma_credit_ctl
    import tx_dma_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int CRED_W = 8,
    parameter int ADDR_W = 12,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic [NCH-1:0]    fifo_full,
    input  logic [NCH-1:0]    xfer_grant,
    input  logic [NCH-1:0]    buf_empty,
    input  logic              act_valid,
    input  logic [CH_W-1:0]   act_chan,
    input  logic [NCH-1:0]    cmd_done,
    input  logic              addr_err_evt,
    input  logic              wc_err_evt,
    output logic [NCH-1:0]    ch_run,
    output logic [NCH-1:0]    ch_stop_eof,
    output logic [NCH-1:0]    ch_req_en,
    output logic              err_irq
);

    localparam int SLOT_MSB = CH_STRIDE_SH + CH_FIELD_W - 1;
    localparam int WSEL_MSB = CH_STRIDE_SH - 1;

    logic [NCH-1:0]             cen_q;
    logic [NCH-1:0]             occ_q;
    logic [NCH-1:0]             cred_evt;
    logic [NCH-1:0]             ovf_evt;
    logic [NCH-1:0][CRED_W-1:0] credit_q;
    tx_mode_e                   mode_q [NCH];
    logic [REG_W-1:0]           err_q;
    logic [REG_W-1:0]           err_set;
    logic                       wr_in_slots;
    logic                       rd_in_slots;
    logic                       err_we;

    // Write decode shared by all slots.
    always_comb begin
        wr_in_slots = wr_en && (wr_addr[ADDR_W-1:SLOT_MSB+1] == '0);
        rd_in_slots = (rd_addr[ADDR_W-1:SLOT_MSB+1] == '0);
        err_we      = wr_en && (wr_addr == ADDR_W'(ERR_ADDR));
    end

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_ch
            logic cfg_we_i;
            logic cred_we_i;
            logic act_hit_i;

            // Per-channel write strobes and activation match.
            always_comb begin
                cfg_we_i  = wr_in_slots
                         && (wr_addr[SLOT_MSB:CH_STRIDE_SH] == CH_FIELD_W'(gi))
                         && (wr_addr[WSEL_MSB:0] == CH_STRIDE_SH'(CFG_OFS * 4));
                cred_we_i = wr_in_slots
                         && (wr_addr[SLOT_MSB:CH_STRIDE_SH] == CH_FIELD_W'(gi))
                         && (wr_addr[WSEL_MSB:0] == CH_STRIDE_SH'(CRED_OFS * 4));
                act_hit_i = act_valid && (act_chan == CH_W'(gi));
            end

            tx_chan_slice #(.CRED_W(CRED_W)) u_slice (
                .clk          (clk),
                .rst_n        (rst_n),
                .cfg_we       (cfg_we_i),
                .cfg_mode_in  (tx_mode_e'(wr_data[MODE_MSB:MODE_LSB])),
                .cfg_cen_in   (wr_data[CEN_BIT]),
                .cred_we      (cred_we_i),
                .cred_in      (wr_data[CRED_W-1:0]),
                .grant        (xfer_grant[gi]),
                .fifo_full    (fifo_full[gi]),
                .act_hit      (act_hit_i),
                .cmd_done     (cmd_done[gi]),
                .mode         (mode_q[gi]),
                .cen          (cen_q[gi]),
                .credit       (credit_q[gi]),
                .occupied     (occ_q[gi]),
                .cred_err_evt (cred_evt[gi]),
                .act_ovf_evt  (ovf_evt[gi])
            );

            // Mode decode to per-channel enables.
            always_comb begin
                ch_run[gi]      = (mode_q[gi] == MODE_RUN);
                ch_stop_eof[gi] = (mode_q[gi] == MODE_STOP_EOF);
                ch_req_en[gi]   = cen_q[gi];
            end
        end
    endgenerate

    // Place error events at their fixed bit positions.
    always_comb begin
        err_set                         = '0;
        err_set[NCH-1:0]                = cred_evt;
        err_set[OVF_LSB+NCH-1:OVF_LSB]  = ovf_evt;
        err_set[WC_ERR_BIT]             = wc_err_evt;
        err_set[ADR_ERR_BIT]            = addr_err_evt;
    end

    tx_err_w1c #(.W(REG_W)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (err_set),
        .clr_we   (err_we),
        .clr_mask (wr_data),
        .err_q    (err_q)
    );

    assign err_irq = |err_q;

    // Read mux over slots, status word and error register.
    always_comb begin
        logic [CH_FIELD_W-1:0] slot;
        slot    = rd_addr[SLOT_MSB:CH_STRIDE_SH];
        rd_data = '0;
        if (rd_in_slots && (int'(slot) < NCH)) begin
            if (rd_addr[WSEL_MSB:0] == CH_STRIDE_SH'(CFG_OFS * 4)) begin
                rd_data[MODE_MSB:MODE_LSB] = mode_q[slot];
                rd_data[CEN_BIT]           = cen_q[slot];
            end else if (rd_addr[WSEL_MSB:0] == CH_STRIDE_SH'(CRED_OFS * 4)) begin
                rd_data[CRED_W-1:0] = credit_q[slot];
            end
        end else if (rd_addr == ADDR_W'(STAT_ADDR)) begin
            rd_data[EMPTY_LSB+NCH-1:EMPTY_LSB] = buf_empty;
            rd_data[IDLE_LSB+NCH-1:IDLE_LSB]   = ~occ_q;
        end else if (rd_addr == ADDR_W'(ERR_ADDR)) begin
            rd_data = err_q;
        end
    end

endmodule

// File: rtl/tx_dma_credit_chk.sv
// Module: assertion checker for tx_dma_credit_ctl, attached by bind.
// Relates input events and register writes to the resulting state.
module tx_dma_credit_chk
    import tx_dma_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int CRED_W = 8,
    parameter int ADDR_W = 12,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [NCH-1:0]             fifo_full,
    input logic                       act_valid,
    input logic [CH_W-1:0]            act_chan,
    input logic                       addr_err_evt,
    input logic                       wc_err_evt,
    input logic                       err_irq,
    input logic [REG_W-1:0]           err_q,
    input logic [NCH-1:0]             cen_q,
    input logic [NCH-1:0]             occ_q,
    input logic [NCH-1:0][CRED_W-1:0] credit_q
);

    AST_ADDR_ERR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err_evt |=> err_q[ADR_ERR_BIT]); // R11

    AST_WC_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wc_err_evt |=> err_q[WC_ERR_BIT]); // R9

    AST_IRQ_FALLS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_irq) |-> ($past(wr_en) && ($past(wr_addr) == ADDR_W'(ERR_ADDR)))); // R12

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_chk
            localparam logic [ADDR_W-1:0] CRED_A = ADDR_W'((gi << CH_STRIDE_SH) + CRED_OFS * 4);

            AST_CREDIT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
                ((credit_q[gi] == '0) && !(wr_en && (wr_addr == CRED_A)))
                |=> (credit_q[gi] == '0)); // R5

            AST_CREDIT_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
                (fifo_full[gi] && cen_q[gi] && (credit_q[gi] != '0))
                |=> err_q[gi]); // R6

            AST_ACT_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
                (act_valid && (act_chan == CH_W'(gi)) && occ_q[gi])
                |=> err_q[OVF_LSB+gi]); // R7
        end
    endgenerate

endmodule

bind tx_dma_credit_ctl tx_dma_credit_chk #(
    .NCH(NCH), .CRED_W(CRED_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .fifo_full    (fifo_full),
    .act_valid    (act_valid),
    .act_chan     (act_chan),
    .addr_err_evt (addr_err_evt),
    .wc_err_evt   (wc_err_evt),
    .err_irq      (err_irq),
    .err_q        (err_q),
    .cen_q        (cen_q),
    .occ_q        (occ_q),
    .credit_q     (credit_q)
);

// File: tb/tb_tx_dma_credit_ctl.sv
module tb_tx_dma_credit_ctl;

    localparam int NCH = 8, CRED_W = 8, ADDR_W = 12, CH_W = 3;
    localparam int NVEC = 6;
    // Each entry: {address, write data, expected read-back}
    localparam logic [75:0] VEC [NVEC] = '{
        {12'h000, 32'hFFFF_FFFF, 32'hC000_0008},  // R2 ch0 reserved bits dropped
        {12'h020, 32'h8000_0008, 32'h8000_0008},  // R2 ch1 run + credit enable
        {12'h0E0, 32'h4000_0000, 32'h4000_0000},  // R2 ch7 stop at end of frame
        {12'h064, 32'h0000_01A5, 32'h0000_00A5},  // R2 ch3 credit truncated
        {12'h0A0, 32'h3FFF_FFF7, 32'h0000_0000},  // R2 ch5 only reserved bits
        {12'h044, 32'hFFFF_FF01, 32'h0000_0001}   // R2 ch2 credit
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic [NCH-1:0] fifo_full = '0, xfer_grant = '0, buf_empty = '0, cmd_done = '0;
    logic act_valid = 1'b0, addr_err_evt = 1'b0, wc_err_evt = 1'b0;
    logic [CH_W-1:0] act_chan = '0;
    logic [NCH-1:0] ch_run, ch_stop_eof, ch_req_en;
    logic err_irq;
    int checks = 0, errors = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    tx_dma_credit_ctl #(.NCH(NCH), .CRED_W(CRED_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .fifo_full(fifo_full),
        .xfer_grant(xfer_grant), .buf_empty(buf_empty), .act_valid(act_valid),
        .act_chan(act_chan), .cmd_done(cmd_done), .addr_err_evt(addr_err_evt),
        .wc_err_evt(wc_err_evt), .ch_run(ch_run), .ch_stop_eof(ch_stop_eof),
        .ch_req_en(ch_req_en), .err_irq(err_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input string tag, input logic [31:0] exp);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    // Drive at a falling edge, let one rising edge register it, return at the next falling edge.
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        buf_empty = 8'hFF;
        repeat (3) step();
        // R1 reset state
        rd(12'h000, "R1 cfg0", 32'h0);
        rd(12'h0E4, "R1 cred7", 32'h0);
        rd(12'h108, "R1 err", 32'h0);
        rd(12'h100, "R1 status", 32'hFFFF_0000);
        chk("R1 irq", {31'b0, err_irq}, 32'h0);
        rst_n = 1'b1;
        step();

        // R2 table walk: write then read back
        for (int k = 0; k < NVEC; k++) begin
            wr(VEC[k][75:64], VEC[k][63:32]);
            rd(VEC[k][75:64], "R2 readback", VEC[k][31:0]);
        end
        // R3 mode decode (ch0 mode 11 is off), R4 enable
        chk("R3 run", {24'b0, ch_run}, 32'h0000_0002);
        chk("R3 stop_eof", {24'b0, ch_stop_eof}, 32'h0000_0080);
        chk("R4 req_en", {24'b0, ch_req_en}, 32'h0000_0003);

        // R5 credit countdown and floor on ch1
        wr(12'h024, 32'd3);
        xfer_grant = 8'h02; step();
        rd(12'h024, "R5 one grant", 32'd2);
        step(); step(); step();
        xfer_grant = '0;
        rd(12'h024, "R5 floor at zero", 32'd0);
        // R5 ch3 has credit enable clear: grants ignored
        xfer_grant = 8'h08; step(); xfer_grant = '0;
        rd(12'h064, "R5 disabled grant", 32'h0000_00A5);

        // R6 zero credit: no error; ch3 disabled: no error
        fifo_full = 8'h0A; step(); fifo_full = '0;
        rd(12'h108, "R6 no error", 32'h0);
        wr(12'h024, 32'd2);
        fifo_full = 8'h02; step(); fifo_full = '0;
        rd(12'h108, "R6 mismatch", 32'h0000_0002);
        chk("R12 irq set", {31'b0, err_irq}, 32'h1);

        // R10 writing 0 leaves bit, writing 1 clears
        wr(12'h108, 32'hFFFF_FFFD);
        rd(12'h108, "R10 zero keeps", 32'h0000_0002);
        wr(12'h108, 32'h0000_0002);
        rd(12'h108, "R10 one clears", 32'h0);
        chk("R12 irq clear", {31'b0, err_irq}, 32'h0);

        // R7 activation: first fills, second overflows, release empties
        act_valid = 1'b1; act_chan = 3'd4; step(); act_valid = 1'b0;
        rd(12'h100, "R8 ch4 pending", 32'hFFEF_0000);
        rd(12'h108, "R7 first no error", 32'h0);
        act_valid = 1'b1; step(); act_valid = 1'b0;
        rd(12'h108, "R7 overflow", 32'h0000_2000);
        cmd_done = 8'h10; step(); cmd_done = '0;
        rd(12'h100, "R7 released", 32'hFFFF_0000);
        wr(12'h108, 32'hFFFF_FFFF);

        // R8 buf_empty pattern
        buf_empty = 8'hA5; #1;
        rd(12'h100, "R8 empty field", 32'hA5FF_0000);

        // R9 internal error events
        addr_err_evt = 1'b1; step(); addr_err_evt = 1'b0;
        rd(12'h108, "R9 addr err", 32'h8000_0000);
        wc_err_evt = 1'b1; step(); wc_err_evt = 1'b0;
        rd(12'h108, "R9 wc err", 32'hC000_0000);
        wr(12'h108, 32'hC000_0000);
        rd(12'h108, "R9 cleared", 32'h0);

        // R11 event beats simultaneous clear
        addr_err_evt = 1'b1;
        wr(12'h108, 32'h8000_0000);
        addr_err_evt = 1'b0;
        rd(12'h108, "R11 set wins", 32'h8000_0000);
        chk("R12 irq held", {31'b0, err_irq}, 32'h1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule